// File: doc/BRIEF.md
# Predicated Subvector Vector Adder

This block adds two packed operand vectors lane by lane and writes the sums into a packed destination vector. Scalars are grouped into subvectors of one to four lanes. The length count and the predicate both work on whole subvectors. A predicate bit enables or disables a whole group of lanes, not a single lane. The predicate can also be used inverted, so that a subvector runs when its bit is 0.

A caller places both operands, the old destination contents, the predicate, the invert flag, the lane width, the subvector size and the vector length on the inputs, then pulses `start_i`. The block latches all of them and works through one subvector per clock. Lanes of a disabled subvector keep their old values. When the pass is over, `done_o` rises for one cycle and `rd_o` holds the result until the next start.

Top module: `subvec_pred_adder`

## Requirements
- R1: `start_i` is accepted only while the block is neither busy nor signalling done. Acceptance latches every operand input and loads the destination register from `rd_i`. A `start_i` raised at any other time has no effect on the result or the timing.
- R2: Each enabled subvector i writes its lanes i*S+k, for k below S. Each lane gets rs1+rs2 modulo 2^width, and no carry passes between lanes. Lane j of width w sits at bits [j*w +: w].
- R3: The block handles exactly one subvector per clock. If `start_i` is accepted at clock edge E0, `done_o` is high for exactly one cycle, starting at edge E(VL).
- R4: Subvector i is enabled by `pred_i[i] XOR pred_inv_i`. With `pred_inv_i`=1, a subvector runs when its bit is 0.
- R5: All lanes of a disabled subvector keep the value loaded from `rd_i`.
- R6: The lane width is chosen by `ew_i`: 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits.
- R7: `subvl_i` holds S-1, so the values 0 to 3 give subvectors of 1 to 4 lanes. S=1 is plain scalar operation.
- R8: A VL of 0 makes no writes. `done_o` rises at the edge that accepts the start, and `rd_o` equals `rd_i`.
- R9: A lane that does not fit entirely inside the vector is not written. A VL above MAX_VL is treated as MAX_VL.
- R10: After reset, `rd_o` is zero, and `busy_o` and `done_o` are low.
- R11: `busy_o` is high from the accepting edge until the edge at which `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a pass |
| rs1_i | input | DATA_W | First operand vector |
| rs2_i | input | DATA_W | Second operand vector |
| rd_i | input | DATA_W | Old destination contents |
| pred_i | input | MAX_VL | Predicate mask, one bit per subvector |
| pred_inv_i | input | 1 | Use the predicate inverted |
| ew_i | input | 2 | Lane width select |
| subvl_i | input | 2 | Subvector size minus one |
| vl_i | input | $clog2(MAX_VL+1) | Number of subvectors |
| rd_o | output | DATA_W | Destination vector |
| busy_o | output | 1 | A pass is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a subvector that straddles the end of the vector, or lies wholly beyond it. Such a subvector must be dropped lane by lane, with no wrap into low bits. The bench reaches it with 32-bit lanes, four-lane subvectors and a VL whose lanes outrun the vector width, and it also sends a VL above MAX_VL. A start pulse raised in the middle of a pass, with different operands, checks that the first pass is not disturbed. A reference model checks every clock against randomized mixes of width, size and predicate.

// File: rtl/svadd_pkg.sv
package svadd_pkg;
  typedef enum logic [1:0] {EW_8 = 2'd0, EW_16 = 2'd1, EW_32 = 2'd2, EW_32X = 2'd3} ew_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_DONE = 2'd2} st_e;

  // log2 of lane size in bytes
  function automatic logic [1:0] ew_shift(ew_e e);
    case (e)
      EW_8:    ew_shift = 2'd0;
      EW_16:   ew_shift = 2'd1;
      default: ew_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/svadd_lane_adder.sv
module svadd_lane_adder #(
  parameter int DATA_W = 256,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int NLANE = DATA_W / LANE_W;

  for (genvar gl = 0; gl < NLANE; gl++) begin : g_lane
    assign sum_o[gl*LANE_W +: LANE_W] = a_i[gl*LANE_W +: LANE_W] + b_i[gl*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/svadd_byte_mask.sv
module svadd_byte_mask #(
  parameter int NBYTES = 32,
  parameter int IDX_W  = 7
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [1:0]       subvl_m1_i,
  input  logic [1:0]       shift_i,
  output logic [NBYTES-1:0] be_o
);
  localparam int BI_W  = $clog2(NBYTES);
  localparam int CMP_W = ((IDX_W > BI_W) ? IDX_W : BI_W) + 1;

  logic [CMP_W-1:0] lo, hi;
  assign lo = CMP_W'(base_i);
  assign hi = lo + CMP_W'(subvl_m1_i) + CMP_W'(1);

  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_byte
    logic [CMP_W-1:0] sidx;
    assign sidx     = CMP_W'(gb) >> shift_i;
    assign be_o[gb] = en_i && (sidx >= lo) && (sidx < hi);
  end

  // R7: never more bytes than one subvector holds
  always_comb begin
    a_r7_mask_bound: assert ($countones(be_o) <= ((int'(subvl_m1_i) + 1) << shift_i));
  end
endmodule

// File: rtl/svadd_ctrl.sv
module svadd_ctrl import svadd_pkg::*; #(
  parameter int MAX_VL = 32,
  parameter int VL_W   = $clog2(MAX_VL + 1),
  parameter int CNT_W  = $clog2(MAX_VL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic              pred_inv_i,
  output logic              load_o,
  output logic              step_o,
  output logic              active_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              busy_o,
  output logic              done_o
);
  st_e               st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [VL_W-1:0]   vl_q, vl_eff;
  logic [MAX_VL-1:0] pred_q;
  logic              inv_q, last;

  assign vl_eff   = (vl_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vl_i;
  assign load_o   = (st_q == ST_IDLE) && start_i;
  assign step_o   = (st_q == ST_RUN);
  assign last     = (VL_W'(cnt_q) + VL_W'(1)) == vl_q;
  assign active_o = step_o && (pred_q[cnt_q] ^ inv_q);
  assign cnt_o    = cnt_q;
  assign busy_o   = step_o;
  assign done_o   = (st_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      vl_q   <= '0;
      pred_q <= '0;
      inv_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          vl_q   <= vl_eff;
          pred_q <= pred_i;
          inv_q  <= pred_inv_i;
          cnt_q  <= '0;
          st_q   <= (vl_eff == '0) ? ST_DONE : ST_RUN;
        end
        ST_RUN: begin
          if (last) st_q <= ST_DONE;
          else      cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_step_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !last) |=> (step_o && cnt_q == $past(cnt_q) + CNT_W'(1)));
  a_r1_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && start_i) |=> ($stable(vl_q) && $stable(pred_q) && $stable(inv_q)));
  a_r8_zero_vl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && vl_i == '0) |=> done_o);
endmodule

// File: rtl/subvec_pred_adder.sv
module subvec_pred_adder import svadd_pkg::*; #(
  parameter int DATA_W = 256,
  parameter int MAX_VL = 32,
  localparam int VL_W  = $clog2(MAX_VL + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] rs1_i,
  input  logic [DATA_W-1:0] rs2_i,
  input  logic [DATA_W-1:0] rd_i,
  input  logic [MAX_VL-1:0] pred_i,
  input  logic              pred_inv_i,
  input  logic [1:0]        ew_i,
  input  logic [1:0]        subvl_i,
  input  logic [VL_W-1:0]   vl_i,
  output logic [DATA_W-1:0] rd_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int NBYTES = DATA_W / 8;
  localparam int CNT_W  = $clog2(MAX_VL);
  localparam int IDX_W  = CNT_W + 2;
  localparam int NWID   = 3;

  logic [DATA_W-1:0] rs1_q, rs2_q, rd_q, rd_nxt, sum_sel;
  logic [1:0]        shift_q, subvl_q;
  logic              load, step, active;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  base;
  logic [NBYTES-1:0] be;
  logic [DATA_W-1:0] sums [NWID];

  svadd_ctrl #(.MAX_VL(MAX_VL), .VL_W(VL_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .vl_i, .pred_i, .pred_inv_i,
    .load_o(load), .step_o(step), .active_o(active), .cnt_o(cnt),
    .busy_o, .done_o
  );

  for (genvar gw = 0; gw < NWID; gw++) begin : g_wid
    svadd_lane_adder #(.DATA_W(DATA_W), .LANE_W(8 << gw)) u_add (
      .a_i(rs1_q), .b_i(rs2_q), .sum_o(sums[gw])
    );
  end

  assign sum_sel = sums[(shift_q > 2'd2) ? 2'd2 : shift_q];
  assign base    = IDX_W'(cnt) * IDX_W'({1'b0, subvl_q} + 3'd1);

  svadd_byte_mask #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_mask (
    .en_i(active), .base_i(base), .subvl_m1_i(subvl_q), .shift_i(shift_q), .be_o(be)
  );

  for (genvar gb = 0; gb < NBYTES; gb++) begin : g_merge
    assign rd_nxt[gb*8 +: 8] = be[gb] ? sum_sel[gb*8 +: 8] : rd_q[gb*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs1_q   <= '0;
      rs2_q   <= '0;
      rd_q    <= '0;
      shift_q <= '0;
      subvl_q <= '0;
    end else if (load) begin
      rs1_q   <= rs1_i;
      rs2_q   <= rs2_i;
      rd_q    <= rd_i;
      shift_q <= ew_shift(ew_e'(ew_i));
      subvl_q <= subvl_i;
    end else if (step) begin
      rd_q <= rd_nxt;
    end
  end

  assign rd_o = rd_q;

  a_r5_masked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && !active) |=> $stable(rd_o));
  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !load) |=> $stable(rd_o));
  a_r1_load_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (rd_o == $past(rd_i)));
endmodule

// File: tb/subvec_pred_adder_bench.sv
module subvec_pred_adder_bench;
  localparam int DATA_W = 256;
  localparam int MAX_VL = 32;
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, pred_inv_i = 1'b0;
  logic [DATA_W-1:0] rs1_i = '0, rs2_i = '0, rd_i = '0, rd_o;
  logic [MAX_VL-1:0] pred_i = '0;
  logic [1:0] ew_i = '0, subvl_i = '0;
  logic [VL_W-1:0] vl_i = '0;
  logic busy_o, done_o;

  int checks = 0, bad = 0, cyc = 0;

  subvec_pred_adder #(.DATA_W(DATA_W), .MAX_VL(MAX_VL)) u_subvec_pred_adder (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference model state
  int m_st = 0, m_cnt = 0, m_vl = 0, m_w = 8, m_s = 1;
  logic [DATA_W-1:0] m_a = '0, m_b = '0, m_rd = '0;
  logic [MAX_VL-1:0] m_pred = '0;
  logic m_inv = 1'b0;

  task automatic m_apply(int i);
    for (int k = 0; k < m_s; k++) begin
      int idx = i * m_s + k;
      if ((idx + 1) * m_w <= DATA_W) begin
        logic [DATA_W-1:0] mask, a, b, s;
        mask = (DATA_W'(1) << m_w) - DATA_W'(1);
        a = (m_a >> (idx * m_w)) & mask;
        b = (m_b >> (idx * m_w)) & mask;
        s = (a + b) & mask;
        m_rd = (m_rd & ~(mask << (idx * m_w))) | (s << (idx * m_w));
      end
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0; m_cnt = 0; m_rd = '0;
    end else begin
      case (m_st)
        0: if (start_i) begin
          m_a = rs1_i; m_b = rs2_i; m_rd = rd_i; m_pred = pred_i; m_inv = pred_inv_i;
          m_w = (ew_i == 2'd0) ? 8 : (ew_i == 2'd1) ? 16 : 32;
          m_s = int'(subvl_i) + 1;
          m_vl = (int'(vl_i) > MAX_VL) ? MAX_VL : int'(vl_i);
          m_cnt = 0;
          m_st = (m_vl == 0) ? 2 : 1;
        end
        1: begin
          if (m_pred[m_cnt] ^ m_inv) m_apply(m_cnt);
          if (m_cnt == m_vl - 1) m_st = 2; else m_cnt++;
        end
        default: m_st = 0;
      endcase
    end
  end

  task automatic finish_sim();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cyc);
      finish_sim();
    end
  end

  task automatic check(bit ok, string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  bit cmp_on = 1'b0;
  always @(negedge clk_i) if (cmp_on) begin
    check(rd_o === m_rd, "R2 R5 rd_o per cycle", rd_o, m_rd);
    check(busy_o === (m_st == 1), "R11 busy_o per cycle", DATA_W'(busy_o), DATA_W'(m_st == 1));
    check(done_o === (m_st == 2), "R3 done_o per cycle", DATA_W'(done_o), DATA_W'(m_st == 2));
  end

  function automatic logic [DATA_W-1:0] rnd_vec();
    logic [DATA_W-1:0] v = '0;
    for (int i = 0; i < DATA_W / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  int lat;
  task automatic run_op(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b, logic [DATA_W-1:0] d,
                        logic [MAX_VL-1:0] p, bit inv, logic [1:0] ew, logic [1:0] sv,
                        logic [VL_W-1:0] vl, bit mid_start);
    rs1_i = a; rs2_i = b; rd_i = d; pred_i = p; pred_inv_i = inv;
    ew_i = ew; subvl_i = sv; vl_i = vl; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    if (mid_start && !done_o) begin
      rs1_i = rnd_vec(); rs2_i = rnd_vec(); rd_i = rnd_vec(); vl_i = 1; start_i = 1'b1;
    end
    while (!done_o && lat < 200) begin
      @(negedge clk_i);
      start_i = 1'b0;
      lat++;
    end
    @(negedge clk_i);
  endtask

  initial begin
    logic [DATA_W-1:0] d0;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check(rd_o === '0, "R10 rd_o after reset", rd_o, '0);
    check(busy_o === 1'b0 && done_o === 1'b0, "R10 flags after reset",
          DATA_W'({busy_o, done_o}), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp_on = 1'b1;

    // R2 R7 R6: wrap in 8-bit lanes, no carry into neighbour lane, S=2
    run_op(DATA_W'(16'h10FF), DATA_W'(16'h2001), {(DATA_W/8){8'hAA}}, 32'h1, 1'b0, 2'd0, 2'd1, 6'd1, 1'b0);
    check(rd_o[15:0] === 16'h3000, "R2 lane wrap no carry", DATA_W'(rd_o[15:0]), DATA_W'(16'h3000));
    check(rd_o[23:16] === 8'hAA, "R7 lane past subvector untouched", DATA_W'(rd_o[23:16]), DATA_W'(8'hAA));
    check(lat == 1, "R3 latency VL=1", DATA_W'(lat), DATA_W'(1));

    // R4 R5 R6: inverted predicate, 16-bit scalars
    run_op({(DATA_W/16){16'h0100}}, {(DATA_W/16){16'h0002}}, '0, 32'h5, 1'b1, 2'd1, 2'd0, 6'd4, 1'b0);
    check(rd_o[63:0] === 64'h0102_0000_0102_0000, "R4 inverted predicate lanes",
          DATA_W'(rd_o[63:0]), DATA_W'(64'h0102_0000_0102_0000));
    check(lat == 4, "R3 latency VL=4", DATA_W'(lat), DATA_W'(4));

    // R9 R6: 32-bit lanes, S=4, VL=3: subvector 2 lies beyond the vector
    d0 = rnd_vec();
    run_op({(DATA_W/32){32'hFFFF_FFFF}}, {(DATA_W/32){32'h0000_0003}}, d0, '1, 1'b0, 2'd3, 2'd3, 6'd3, 1'b0);
    check(rd_o === {(DATA_W/32){32'h0000_0002}}, "R9 overhanging lanes dropped",
          rd_o, {(DATA_W/32){32'h0000_0002}});

    // R8: VL of zero
    d0 = rnd_vec();
    run_op(rnd_vec(), rnd_vec(), d0, '1, 1'b0, 2'd0, 2'd0, 6'd0, 1'b0);
    check(rd_o === d0, "R8 VL=0 no writes", rd_o, d0);
    check(lat == 0, "R8 VL=0 immediate done", DATA_W'(lat), '0);

    // R9: VL above MAX_VL clamps
    run_op(rnd_vec(), rnd_vec(), rnd_vec(), '1, 1'b0, 2'd0, 2'd0, 6'd40, 1'b0);
    check(lat == MAX_VL, "R9 VL clamp latency", DATA_W'(lat), DATA_W'(MAX_VL));

    // R1: start during a pass is ignored
    run_op(rnd_vec(), rnd_vec(), rnd_vec(), 32'hA5A5_5A5A, 1'b0, 2'd1, 2'd2, 6'd5, 1'b1);
    check(lat == 5, "R1 mid-pass start ignored", DATA_W'(lat), DATA_W'(5));

    // randomized mixes checked every cycle by the model
    for (int t = 0; t < 40; t++) begin
      run_op(rnd_vec(), rnd_vec(), rnd_vec(), MAX_VL'($urandom), 1'($urandom),
             2'($urandom), 2'($urandom), VL_W'($urandom_range(0, 36)), 1'($urandom));
    end

    cmp_on = 1'b0;
    finish_sim();
  end
endmodule